// File: doc/BRIEF.md
# Machine Cycle and Bus Timing Sequencer

This block derives the internal timing of a classic 8-bit microcontroller core from its crystal clock. Each machine cycle has six states, S1 to S6, and each state has two phases, P1 and P2. That gives twelve clocks per machine cycle. The block reports the current state and phase to the rest of the core. It also produces a phase-2 indicator for serial logic and two strobes that mark when program-memory bytes are sampled: a possible opcode at S1P1 and a second byte at S4P1.

From the same count the block drives the external program-fetch bus. It produces an address strobe, which is the OR of the fetch-side request and a request from the data-access side. It also produces an active-low program read strobe. It places the fetch address on the low and high bus bytes. When the execution unit raises a data-transfer request, fetch stops driving the bus and its strobes, and the data side owns both bus bytes. A flag marks the next opcode sample as unusable. In reset, every driven bus output is released to high impedance. The block reports this through separate output-enable signals.

Top module: `mcs_cycle_seq`

## Requirements
- R1: In reset the sequencer sits at S1P1 (`state_o`=0, `ph2_o`=0). After reset it advances one phase per clock and wraps after twelve clocks. `state_o` encodes S1..S6 as 0..5.
- R2: `ph2_o` is high during the P2 phase of every state and low during every P1 phase.
- R3: `op_samp_o` is high only in S1P1, and `arg_samp_o` is high only in S4P1.
- R4: With external fetch selected (`ext_prog_n_i`=0) and no data request, the fetch side raises the address strobe in S1P2, S2P1, S4P2 and S5P1. In those phases `lo_bus_o` carries the low byte of `fetch_addr_i`, with `lo_bus_oe_o`=1.
- R5: In external fetch, `pfrd_n_o` is low throughout S3, S4 and S6. It is also low in S1, but only when the previous S6 was an active fetch window. It therefore stays high in the first S1 after reset.
- R6: With internal fetch selected (`ext_prog_n_i`=1), there is no fetch address strobe and `pfrd_n_o` stays high. Both bus bytes drive their port latch values with the enables set.
- R7: `strb_o` is the OR of the fetch-side address strobe and `xdata_strb_i`.
- R8: While `xdata_req_i` is high, fetch strobes are suppressed (`pfrd_n_o`=1, no fetch address strobe). The low bus carries `xd_lo_i` with enable `xd_lo_oe_i`, and the high bus carries `xd_hi_i`.
- R9: `lat_lo_ones_o` is high whenever the low bus is used for address or data: fetch strobe phases, fetch read phases, or a data request. It is low when the low bus shows its latch.
- R10: `op_bad_o` is high at S1P1 when `xdata_req_i` was high in S6P1 or S6P2 of the previous cycle, or is high in that S1P1. It is otherwise low.
- R11: While `rst_n` is low, `strb_oe_o`, `lo_bus_oe_o` and `hi_bus_oe_o` are 0 and `pfrd_n_o` is 1.
- R12: In external fetch with no data request, `hi_bus_o` carries the high byte of `fetch_addr_i` with `hi_bus_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, one phase per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_prog_n_i | input | 1 | Low selects external program memory |
| xdata_req_i | input | 1 | Data-access side claims the bus |
| xdata_strb_i | input | 1 | Address strobe request from the data-access side |
| fetch_addr_i | input | 16 | Program fetch address |
| xd_lo_i | input | 8 | Data-side value for the low bus byte |
| xd_lo_oe_i | input | 1 | Data-side drive enable for the low bus byte |
| xd_hi_i | input | 8 | Data-side value for the high bus byte |
| lat_lo_i | input | 8 | Low port latch value |
| lat_hi_i | input | 8 | High port latch value |
| state_o | output | 3 | Current state, 0..5 for S1..S6 |
| ph2_o | output | 1 | High in phase P2 |
| op_samp_o | output | 1 | Opcode sample point (S1P1) |
| arg_samp_o | output | 1 | Second byte sample point (S4P1) |
| op_bad_o | output | 1 | Opcode sample unusable, fetch was suspended |
| strb_o | output | 1 | External address strobe |
| strb_oe_o | output | 1 | Drive enable of the address strobe |
| pfrd_n_o | output | 1 | Active-low program read strobe |
| lo_bus_o | output | 8 | Low address/data bus byte |
| lo_bus_oe_o | output | 1 | Drive enable of the low bus byte |
| hi_bus_o | output | 8 | High address bus byte |
| hi_bus_oe_o | output | 1 | Drive enable of the high bus byte |
| lat_lo_ones_o | output | 1 | Request to force the low port latch to all ones |

## Verification
The bench builds the block with its defaults: six states, two phases and an 8-bit bus. At those settings every one of the twelve phase positions and the wrap from S6P2 to S1P1 are observed directly. The same holds for the S1 read tail that depends on the previous S6, and for its absence after reset. A single stimulus phase is enough to place a data request on S5, on S6P1, on S6P2 or on S1P1. This makes the capture window behind the opcode-invalid flag visible at both edges.

// File: rtl/mcs_pkg.sv
`timescale 1ns/100ps
// Package: shared constants of the machine cycle sequencer.
// Assumes state numbering starts at S1 = 0 and phase P1 = 0.
package mcs_pkg;
    localparam int unsigned MC_STATES = 6;
    localparam int unsigned MC_PHASES = 2;
    localparam int unsigned BUS_W     = 8;

    // State indices used by the strobe windows.
    localparam int unsigned ST_1 = 0;
    localparam int unsigned ST_2 = 1;
    localparam int unsigned ST_3 = 2;
    localparam int unsigned ST_4 = 3;
    localparam int unsigned ST_5 = 4;
    localparam int unsigned ST_6 = 5;

    // Fetch-side controls passed from the strobe generator to the bus mux.
    typedef struct packed {
        logic addr_stb;
        logic rd_win;
    } fetch_ctl_t;
endpackage

// File: rtl/mcs_tick_counter.sv
`timescale 1ns/100ps
// Module: state/phase counter. Counts phases within a state and states
// within a machine cycle. Assumes NPH >= 2 and NST >= 6.
module mcs_tick_counter #(
    parameter int unsigned NST = mcs_pkg::MC_STATES,
    parameter int unsigned NPH = mcs_pkg::MC_PHASES,
    localparam int unsigned SW = $clog2(NST),
    localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] st_o,
    output logic [PW-1:0] ph_o
);
    localparam logic [SW-1:0] ST_LAST = SW'(NST - 1);
    localparam logic [PW-1:0] PH_LAST = PW'(NPH - 1);

    logic [SW-1:0] st_q;
    logic [PW-1:0] ph_q;

    // Advance the phase every clock, and the state at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
            st_q <= (st_q == ST_LAST) ? '0 : st_q + SW'(1);
        end else begin
            ph_q <= ph_q + PW'(1);
        end
    end

    assign st_o = st_q;
    assign ph_o = ph_q;

    AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LAST && ph_q == PH_LAST) |=> (st_q == '0 && ph_q == '0)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_LAST) |=> (ph_q == $past(ph_q) + PW'(1) && $stable(st_q))); // R1
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q <= ST_LAST)); // R1
endmodule

// File: rtl/mcs_fetch_seq.sv
`timescale 1ns/100ps
// Module: program fetch strobe generator. Derives the fetch address strobe
// windows, the read window (including the S1 tail that continues an S6
// read) and the opcode-invalid flag. Assumes state/phase come from
// mcs_tick_counter and that a hold request suppresses all fetch strobes.
module mcs_fetch_seq #(
    parameter int unsigned NST = mcs_pkg::MC_STATES,
    parameter int unsigned NPH = mcs_pkg::MC_PHASES,
    localparam int unsigned SW = $clog2(NST),
    localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SW-1:0]      st_i,
    input  logic [PW-1:0]      ph_i,
    input  logic               ext_en_i,
    input  logic               hold_i,
    output mcs_pkg::fetch_ctl_t ctl_o,
    output logic               op_bad_o
);
    import mcs_pkg::*;

    localparam logic [SW-1:0] S1 = SW'(ST_1);
    localparam logic [SW-1:0] S2 = SW'(ST_2);
    localparam logic [SW-1:0] S3 = SW'(ST_3);
    localparam logic [SW-1:0] S4 = SW'(ST_4);
    localparam logic [SW-1:0] S5 = SW'(ST_5);
    localparam logic [SW-1:0] S6 = SW'(ST_6);
    localparam logic [PW-1:0] PH_LAST = PW'(NPH - 1);

    logic ph_first, ph_last, fetch_on, stb_tick, rd_tick;
    logic tail_q, susp_q;

    // Decode the phase positions of the fetch strobe windows.
    always_comb begin
        ph_first = (ph_i == '0);
        ph_last  = (ph_i == PH_LAST);
        fetch_on = ext_en_i & ~hold_i;
        stb_tick = (st_i == S1 && ph_last) || (st_i == S2 && ph_first) ||
                   (st_i == S4 && ph_last) || (st_i == S5 && ph_first);
        rd_tick  = (st_i == S3) || (st_i == S4) || (st_i == S6) ||
                   (st_i == S1 && tail_q);
    end

    // Remember whether the S6 read window was active so that S1 continues it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= 1'b0;
        else if (st_i == S6 && ph_last)
            tail_q <= fetch_on;
    end

    // Collect any hold request seen during S6 for the next opcode sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            susp_q <= 1'b0;
        else if (st_i == S6 && ph_first)
            susp_q <= hold_i;
        else if (st_i == S6)
            susp_q <= susp_q | hold_i;
    end

    assign ctl_o.addr_stb = fetch_on & stb_tick;
    assign ctl_o.rd_win   = fetch_on & rd_tick;
    assign op_bad_o       = (st_i == S1) && ph_first && (susp_q | hold_i);

    AST_TAIL_FROM_S6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tail_q) |-> ($past(st_i) == S6)); // R5
    AST_TAIL_CLEARED_BY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == S6 && ph_last && hold_i) |=> !tail_q); // R5
endmodule

// File: rtl/mcs_port_mux.sv
`timescale 1ns/100ps
// Module: bus byte multiplexer. Selects what the low and high bus bytes
// carry (fetch address, data-side values, or port latches) and their drive
// enables. Assumes the hold request gives the data side priority over fetch.
module mcs_port_mux #(
    parameter int unsigned DW = mcs_pkg::BUS_W,
    localparam int unsigned AW = 2 * DW
) (
    input  logic                rst_n,
    input  mcs_pkg::fetch_ctl_t ctl_i,
    input  logic                ext_en_i,
    input  logic                hold_i,
    input  logic [AW-1:0]       fetch_addr_i,
    input  logic [DW-1:0]       xd_lo_i,
    input  logic                xd_lo_oe_i,
    input  logic [DW-1:0]       xd_hi_i,
    input  logic [DW-1:0]       lat_lo_i,
    input  logic [DW-1:0]       lat_hi_i,
    output logic [DW-1:0]       lo_o,
    output logic                lo_oe_o,
    output logic [DW-1:0]       hi_o,
    output logic                hi_oe_o,
    output logic                lat_lo_ones_o
);
    // Low byte: data side, then fetch address, then fetch read, then latch.
    always_comb begin
        lo_o          = lat_lo_i;
        lo_oe_o       = 1'b1;
        lat_lo_ones_o = 1'b0;
        if (!rst_n) begin
            lo_oe_o = 1'b0;
        end else if (hold_i) begin
            lo_o          = xd_lo_i;
            lo_oe_o       = xd_lo_oe_i;
            lat_lo_ones_o = 1'b1;
        end else if (ctl_i.addr_stb) begin
            lo_o          = fetch_addr_i[DW-1:0];
            lat_lo_ones_o = 1'b1;
        end else if (ctl_i.rd_win) begin
            lo_oe_o       = 1'b0;
            lat_lo_ones_o = 1'b1;
        end
    end

    // High byte: data side, then fetch address, then latch.
    always_comb begin
        hi_o    = lat_hi_i;
        hi_oe_o = 1'b1;
        if (!rst_n)
            hi_oe_o = 1'b0;
        else if (hold_i)
            hi_o = xd_hi_i;
        else if (ext_en_i)
            hi_o = fetch_addr_i[AW-1:DW];
    end

    // A released low byte while running always belongs to a bus transfer.
    always_comb begin
        AST_LATCH_SET_WHEN_FLOATING: assert (!rst_n || lo_oe_o || lat_lo_ones_o); // R9
    end
endmodule

// File: rtl/mcs_cycle_seq.sv
`timescale 1ns/100ps
// Module: machine cycle and bus timing sequencer (top). Combines the
// state/phase counter, the fetch strobe generator and the bus mux, and
// merges fetch and data-side address strobe requests. Assumes a
// synchronous active-low reset and one phase per clock.
module mcs_cycle_seq #(
    parameter int unsigned NST = mcs_pkg::MC_STATES,
    parameter int unsigned NPH = mcs_pkg::MC_PHASES,
    parameter int unsigned DW  = mcs_pkg::BUS_W,
    localparam int unsigned SW = $clog2(NST),
    localparam int unsigned PW = (NPH > 1) ? $clog2(NPH) : 1,
    localparam int unsigned AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_prog_n_i,
    input  logic          xdata_req_i,
    input  logic          xdata_strb_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [DW-1:0] xd_lo_i,
    input  logic          xd_lo_oe_i,
    input  logic [DW-1:0] xd_hi_i,
    input  logic [DW-1:0] lat_lo_i,
    input  logic [DW-1:0] lat_hi_i,
    output logic [SW-1:0] state_o,
    output logic          ph2_o,
    output logic          op_samp_o,
    output logic          arg_samp_o,
    output logic          op_bad_o,
    output logic          strb_o,
    output logic          strb_oe_o,
    output logic          pfrd_n_o,
    output logic [DW-1:0] lo_bus_o,
    output logic          lo_bus_oe_o,
    output logic [DW-1:0] hi_bus_o,
    output logic          hi_bus_oe_o,
    output logic          lat_lo_ones_o
);
    import mcs_pkg::*;

    localparam logic [SW-1:0] S1 = SW'(ST_1);
    localparam logic [SW-1:0] S4 = SW'(ST_4);
    localparam logic [PW-1:0] PH_LAST = PW'(NPH - 1);

    logic [SW-1:0] st;
    logic [PW-1:0] ph;
    logic          ext_en;
    fetch_ctl_t    fctl;

    assign ext_en = ~ext_prog_n_i;

    mcs_tick_counter #(.NST(NST), .NPH(NPH)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .st_o  (st),
        .ph_o  (ph)
    );

    mcs_fetch_seq #(.NST(NST), .NPH(NPH)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_i     (st),
        .ph_i     (ph),
        .ext_en_i (ext_en),
        .hold_i   (xdata_req_i),
        .ctl_o    (fctl),
        .op_bad_o (op_bad_o)
    );

    mcs_port_mux #(.DW(DW)) u_mux (
        .rst_n         (rst_n),
        .ctl_i         (fctl),
        .ext_en_i      (ext_en),
        .hold_i        (xdata_req_i),
        .fetch_addr_i  (fetch_addr_i),
        .xd_lo_i       (xd_lo_i),
        .xd_lo_oe_i    (xd_lo_oe_i),
        .xd_hi_i       (xd_hi_i),
        .lat_lo_i      (lat_lo_i),
        .lat_hi_i      (lat_hi_i),
        .lo_o          (lo_bus_o),
        .lo_oe_o       (lo_bus_oe_o),
        .hi_o          (hi_bus_o),
        .hi_oe_o       (hi_bus_oe_o),
        .lat_lo_ones_o (lat_lo_ones_o)
    );

    // Indicators for the rest of the core.
    always_comb begin
        state_o    = st;
        ph2_o      = (ph == PH_LAST);
        op_samp_o  = (st == S1) && (ph == '0);
        arg_samp_o = (st == S4) && (ph == '0);
    end

    // External strobes: OR of both requesters, released in reset.
    always_comb begin
        strb_o    = fctl.addr_stb | xdata_strb_i;
        strb_oe_o = rst_n;
        pfrd_n_o  = ~(fctl.rd_win & rst_n);
    end

    AST_PH2_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ph2_o != $past(ph2_o))); // R2
    AST_OPSAMP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_samp_o |=> !op_samp_o); // R3
    AST_REQ_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        xdata_req_i |-> pfrd_n_o); // R8
    AST_STRB_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        xdata_strb_i |-> strb_o); // R7
    AST_BAD_AT_OPSAMP: assert property (@(posedge clk) disable iff (!rst_n)
        op_bad_o |-> op_samp_o); // R10

    // All drivers released while reset is asserted.
    always_comb begin
        AST_FLOAT_IN_RESET: assert (rst_n || (!strb_oe_o && !lo_bus_oe_o &&
                                    !hi_bus_oe_o && pfrd_n_o)); // R11
    end
endmodule

// File: tb/sim_mcs_cycle_seq.sv
`timescale 1ns/100ps
// Bench: walks a per-phase expectation table over three machine cycles,
// then directed tests for internal fetch, data requests, the opcode-invalid
// window and reset in mid-cycle.
module sim_mcs_cycle_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_prog_n = 1'b0;
    logic        xreq = 1'b0;
    logic        xstrb = 1'b0;
    logic [15:0] faddr = 16'hA55A;
    logic [7:0]  xlo = 8'h3C;
    logic        xlo_oe = 1'b0;
    logic [7:0]  xhi = 8'hC3;
    logic [7:0]  lat_lo = 8'h81;
    logic [7:0]  lat_hi = 8'h42;

    logic [2:0]  state;
    logic        ph2, op_samp, arg_samp, op_bad, strb, strb_oe, pfrd_n;
    logic [7:0]  lo_bus, hi_bus;
    logic        lo_oe, hi_oe, lat_ones;

    int errs = 0;
    int nchk = 0;
    int tk = 0;

    always #2.5 clk = ~clk;

    mcs_cycle_seq u0 (
        .clk (clk), .rst_n (rst_n), .ext_prog_n_i (ext_prog_n),
        .xdata_req_i (xreq), .xdata_strb_i (xstrb), .fetch_addr_i (faddr),
        .xd_lo_i (xlo), .xd_lo_oe_i (xlo_oe), .xd_hi_i (xhi),
        .lat_lo_i (lat_lo), .lat_hi_i (lat_hi),
        .state_o (state), .ph2_o (ph2), .op_samp_o (op_samp),
        .arg_samp_o (arg_samp), .op_bad_o (op_bad), .strb_o (strb),
        .strb_oe_o (strb_oe), .pfrd_n_o (pfrd_n), .lo_bus_o (lo_bus),
        .lo_bus_oe_o (lo_oe), .hi_bus_o (hi_bus), .hi_bus_oe_o (hi_oe),
        .lat_lo_ones_o (lat_ones)
    );

    // Per phase position 0..11: {strb, pfrd_n, ph2, op_samp, arg_samp, lo_oe, lat_ones}
    localparam logic [6:0] EXP_TBL [12] = '{
        7'b0001001, 7'b1010011, 7'b1100011, 7'b0110010,
        7'b0000001, 7'b0010001, 7'b0000101, 7'b1010011,
        7'b1100011, 7'b0110010, 7'b0000001, 7'b0010001
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Move to the next phase; inputs may then be set, sampling follows #1.
    task automatic tick();
        @(posedge clk);
        #0.5;
        tk = (tk == 11) ? 0 : tk + 1;
    endtask

    initial begin
        #(100000 * 5);
        errs++;
        nchk++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        // Reset: drivers released (R11).
        repeat (3) @(posedge clk);
        #1.5;
        chk("R11", "strb_oe in reset", 32'(strb_oe), 0);
        chk("R11", "lo_oe in reset", 32'(lo_oe), 0);
        chk("R11", "hi_oe in reset", 32'(hi_oe), 0);
        chk("R11", "pfrd_n in reset", 32'(pfrd_n), 1);
        chk("R1", "state in reset", 32'(state), 0);

        @(posedge clk);
        #0.5 rst_n = 1'b1;
        tk = 0;
        #1;
        // Table walk: three cycles of external fetch.
        for (int i = 0; i < 36; i++) begin
            logic [6:0] e;
            int t;
            if (i > 0) begin
                tick();
                #1;
            end
            t = i % 12;
            e = EXP_TBL[t];
            if (i < 12 && t < 2) e[5] = 1'b1;      // no S1 read tail after reset (R5)
            if (i == 0) begin
                e[1] = 1'b1;                        // low bus shows latch
                e[0] = 1'b0;
            end
            chk("R1", "state", 32'(state), 32'(t / 2));
            chk("R2", "ph2", 32'(ph2), 32'(e[4]));
            chk("R3", "op_samp", 32'(op_samp), 32'(e[3]));
            chk("R3", "arg_samp", 32'(arg_samp), 32'(e[2]));
            chk("R4", "strb", 32'(strb), 32'(e[6]));
            chk("R5", "pfrd_n", 32'(pfrd_n), 32'(e[5]));
            chk("R4", "lo_oe", 32'(lo_oe), 32'(e[1]));
            chk("R9", "lat_ones", 32'(lat_ones), 32'(e[0]));
            chk("R10", "op_bad idle", 32'(op_bad), 0);
            chk("R12", "hi_bus", 32'(hi_bus), 32'(faddr[15:8]));
            chk("R12", "hi_oe", 32'(hi_oe), 1);
            if (e[6]) chk("R4", "lo_bus addr", 32'(lo_bus), 32'(faddr[7:0]));
        end

        // Internal fetch (R6).
        for (int j = 0; j < 12; j++) begin
            tick();
            if (j == 0) ext_prog_n = 1'b1;
            #1;
            chk("R6", "strb internal", 32'(strb), 0);
            chk("R6", "pfrd_n internal", 32'(pfrd_n), 1);
            chk("R6", "lo_bus latch", 32'(lo_bus), 32'(lat_lo));
            chk("R6", "lo_oe latch", 32'(lo_oe), 1);
            chk("R6", "hi_bus latch", 32'(hi_bus), 32'(lat_hi));
            chk("R9", "lat_ones internal", 32'(lat_ones), 0);
        end

        // Data-side strobe merge (R7).
        tick();
        xstrb = 1'b1;
        #1;
        chk("R7", "strb from data side", 32'(strb), 1);
        tick();
        xstrb = 1'b0;
        #1;
        chk("R7", "strb released", 32'(strb), 0);

        // Data request over a full external cycle (R8), ending at S6P2.
        ext_prog_n = 1'b0;
        while (tk != 11) tick();
        for (int j = 0; j < 12; j++) begin
            tick();
            xreq = 1'b1;
            xlo_oe = j[0];
            #1;
            chk("R8", "pfrd_n held", 32'(pfrd_n), 1);
            chk("R8", "strb held", 32'(strb), 0);
            chk("R8", "lo_bus data", 32'(lo_bus), 32'(xlo));
            chk("R8", "lo_oe data", 32'(lo_oe), 32'(xlo_oe));
            chk("R8", "hi_bus data", 32'(hi_bus), 32'(xhi));
            chk("R9", "lat_ones data", 32'(lat_ones), 1);
        end
        tick();
        xreq = 1'b0;
        #1;
        chk("R10", "op_bad after S6 hold", 32'(op_bad), 1);
        chk("R5", "pfrd_n no tail after hold", 32'(pfrd_n), 1);

        // Hold only in S5: opcode sample stays valid (R10).
        while (tk != 8) tick();
        xreq = 1'b1;
        tick();
        xreq = 1'b0;
        while (tk != 0) tick();
        #1;
        chk("R10", "op_bad hold in S5", 32'(op_bad), 0);

        // Hold only in S6P1 (R10).
        while (tk != 10) tick();
        xreq = 1'b1;
        tick();
        xreq = 1'b0;
        tick();
        #1;
        chk("R10", "op_bad hold S6P1", 32'(op_bad), 1);

        // Hold only in S6P2 (R10).
        while (tk != 11) tick();
        xreq = 1'b1;
        tick();
        xreq = 1'b0;
        #1;
        chk("R10", "op_bad hold S6P2", 32'(op_bad), 1);

        // Hold in S1P1 itself (R10).
        tick();
        while (tk != 0) tick();
        xreq = 1'b1;
        #1;
        chk("R10", "op_bad hold S1P1", 32'(op_bad), 1);
        xreq = 1'b0;

        // Reset in mid-cycle returns to S1P1 (R1, R11).
        while (tk != 5) tick();
        rst_n = 1'b0;
        #1;
        chk("R11", "strb_oe mid reset", 32'(strb_oe), 0);
        chk("R11", "lo_oe mid reset", 32'(lo_oe), 0);
        tick();
        #1;
        chk("R1", "state after reset edge", 32'(state), 0);
        tick();
        rst_n = 1'b1;
        tk = 0;
        #1;
        chk("R1", "restart S1P1", 32'(op_samp), 1);
        chk("R5", "pfrd_n first S1", 32'(pfrd_n), 1);
        tick();
        #1;
        chk("R2", "restart ph2", 32'(ph2), 1);
        tick();
        #1;
        chk("R1", "restart S2", 32'(state), 1);

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule